// File: doc/BRIEF.md
# Voltage-ID Target Sequencer

This block chooses the voltage-identification code that a regulator's DAC tracks. A rising edge on the enable input latches three things from the code bus in the same clock: the operating mode, a two-bit boot index, and the bus value present at that moment. The DAC code then leaves the off code and moves toward the boot target, one LSB for each soft-start tick.

In parallel mode the six-bit bus carries target codes. A new value becomes the target once it has been identical on two consecutive clock samples and differs from the last accepted value. A new target replaces the current one at once, even in the middle of a ramp. After the first such code, or after the boot target has been reached, the code moves only on the slew tick.

In serial mode the bus is not used as a target. The block ramps to the boot target and holds it there. Power-good follows the done flag. In serial mode it is also gated by the external power-ok input, which parallel mode ignores.

Top module: `vid_target_seq`

## Requirements
- R1: At the clock edge where `en` is sampled high after being low, the boot index is {`vid[2]`,`vid[3]`}, with `vid[2]` as the high bit. The boot target code is 18 + 4*index: 00 gives 18 (1.1 V), 01 gives 22 (1.0 V), 10 gives 26 (0.9 V) and 11 gives 30 (0.8 V). A code maps to 1.55 V minus 25 mV per count.
- R2: `par_mode` is `vid[1]` as sampled at that same edge (1 = parallel, 0 = serial). It holds that value while `en` stays high and reads 0 while `en` is low.
- R3: After enable, `dac_code` starts from the off code 63. Before the boot target is first reached, and before any parallel code is accepted, `dac_code` moves one count toward the target for each clock in which `ss_tick` is high, and `slew_tick` has no effect.
- R4: `ss_done` rises one clock after `dac_code` first equals the target. It then stays high until `en` goes low.
- R5: A clock with `en` low (or `rst` high) sets `dac_code` to 63 and `ss_done` to 0 on the following clock.
- R6: In parallel mode a bus value is accepted as the new target when it is equal on two consecutive clock samples and differs from the last accepted value. The value present at enable counts as accepted.
- R7: A target accepted while a ramp is under way redirects the ramp. Later steps head for the new value, including in the opposite direction.
- R8: Once a parallel code has been accepted, or `ss_done` has been set, `dac_code` moves only on `slew_tick`, and `ss_tick` has no effect.
- R9: `pgood` equals `ss_done` in parallel mode, whatever the value of `pwr_ok`. In serial mode `pgood` is `ss_done` AND `pwr_ok`.
- R10: In serial mode, changes on the bus never change the target. `dac_code` stays at the boot target.
- R11: A bus value that is present for only one clock sample is not accepted.
- R12: `dac_code` changes by at most one count per clock, and does not change in a clock where the selected tick is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Regulator enable; its rising edge starts a session |
| vid | input | 6 | Code bus: parallel target, and mode and boot bits at enable |
| ss_tick | input | 1 | Soft-start rate pulse |
| slew_tick | input | 1 | Regular slew rate pulse |
| pwr_ok | input | 1 | External power-ok, used only in serial mode |
| dac_code | output | 6 | Current DAC code |
| par_mode | output | 1 | 1 when parallel mode was latched |
| ss_done | output | 1 | Target first reached since enable |
| pgood | output | 1 | Power-good indication |

## Verification
Directed sessions cover each boot index and both values of the mode bit. This shows whether the boot mapping and the mode latch read the right bus bits. A code held on the bus during a ramp shows whether the ramp is redirected and whether the step rate switches from the soft-start tick to the slew tick. A one-clock bus glitch, and bus changes made in serial mode, show whether the acceptance filter and the mode gating work. Random sessions mix tick densities, `pwr_ok` toggles, held and glitched codes, and enable drops. A cycle model in the bench predicts every output on every clock.

// File: rtl/vid_seq_pkg.sv
package vid_seq_pkg;
  typedef enum logic {MODE_SERIAL = 1'b0, MODE_PARALLEL = 1'b1} vid_mode_e;

  // boot target as an integer count
  function automatic int unsigned boot_level(input logic [1:0] idx,
                                             input int unsigned base,
                                             input int unsigned step);
    return base + step * int'(idx);
  endfunction
endpackage

// File: rtl/vid_enable_capture.sv
module vid_enable_capture
  import vid_seq_pkg::*;
#(
  parameter int CODE_W    = 6,
  parameter int BOOT_BASE = 18,
  parameter int BOOT_STEP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              mode_bit,
  input  logic              boot_hi,
  input  logic              boot_lo,
  output logic              en_rise,
  output logic              active,
  output vid_mode_e         mode,
  output logic [CODE_W-1:0] boot_tgt
);
  logic en_q;

  assign en_rise  = en & ~en_q;
  assign boot_tgt = CODE_W'(boot_level({boot_hi, boot_lo}, BOOT_BASE, BOOT_STEP));

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      active <= 1'b0;
      mode   <= MODE_SERIAL;
    end else begin
      en_q <= en;
      if (!en) begin
        active <= 1'b0;
        mode   <= MODE_SERIAL;
      end else if (en_rise) begin
        active <= 1'b1;
        mode   <= mode_bit ? MODE_PARALLEL : MODE_SERIAL;
      end
    end
  end
endmodule

// File: rtl/vid_code_filter.sv
module vid_code_filter #(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_rise,
  input  logic              accept_en,
  input  logic [CODE_W-1:0] vid,
  output logic              new_code_vld,
  output logic [CODE_W-1:0] new_code
);
  logic [CODE_W-1:0] samp_q;
  logic [CODE_W-1:0] acc_q;

  assign new_code     = vid;
  assign new_code_vld = accept_en && (vid == samp_q) && (vid != acc_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      samp_q <= '0;
      acc_q  <= '0;
    end else begin
      samp_q <= vid;
      if (en_rise || new_code_vld) acc_q <= vid;
    end
  end
endmodule

// File: rtl/vid_dac_stepper.sv
module vid_dac_stepper #(
  parameter int CODE_W = 6,
  parameter logic [CODE_W-1:0] OFF_CODE = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              en_rise,
  input  logic              active,
  input  logic [CODE_W-1:0] boot_tgt,
  input  logic              new_code_vld,
  input  logic [CODE_W-1:0] new_code,
  input  logic              ss_tick,
  input  logic              slew_tick,
  output logic [CODE_W-1:0] cur,
  output logic              done,
  output logic              step_evt
);
  logic [CODE_W-1:0] tgt_q;
  logic              slew_sel_q;
  logic              tick_sel;

  function automatic logic [CODE_W-1:0] toward(input logic [CODE_W-1:0] c,
                                               input logic [CODE_W-1:0] t);
    if (c < t) return c + 1'b1;
    if (c > t) return c - 1'b1;
    return c;
  endfunction

  assign tick_sel = slew_sel_q ? slew_tick : ss_tick;
  assign step_evt = active && tick_sel && (cur != tgt_q);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cur        <= OFF_CODE;
      tgt_q      <= OFF_CODE;
      done       <= 1'b0;
      slew_sel_q <= 1'b0;
    end else if (en_rise) begin
      tgt_q      <= boot_tgt;
      slew_sel_q <= 1'b0;
    end else if (active) begin
      if (new_code_vld) begin
        tgt_q      <= new_code;
        slew_sel_q <= 1'b1;
      end
      if (step_evt) cur <= toward(cur, tgt_q);
      if (cur == tgt_q) begin
        done       <= 1'b1;
        slew_sel_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/vid_target_seq.sv
module vid_target_seq
  import vid_seq_pkg::*;
#(
  parameter int CODE_W    = 6,
  parameter int MODE_BIT  = 1,
  parameter int BOOT_HI   = 2,
  parameter int BOOT_LO   = 3,
  parameter int BOOT_BASE = 18,
  parameter int BOOT_STEP = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [CODE_W-1:0] vid,
  input  logic              ss_tick,
  input  logic              slew_tick,
  input  logic              pwr_ok,
  output logic [CODE_W-1:0] dac_code,
  output logic              par_mode,
  output logic              ss_done,
  output logic              pgood
);
  localparam logic [CODE_W-1:0] OFF_CODE = '1;

  logic              en_rise;
  logic              active;
  vid_mode_e         mode;
  logic [CODE_W-1:0] boot_tgt;
  logic              new_code_vld;
  logic [CODE_W-1:0] new_code;
  logic              step_evt;

  vid_enable_capture #(
    .CODE_W(CODE_W), .BOOT_BASE(BOOT_BASE), .BOOT_STEP(BOOT_STEP)
  ) u_cap (
    .clk(clk), .rst(rst), .en(en),
    .mode_bit(vid[MODE_BIT]), .boot_hi(vid[BOOT_HI]), .boot_lo(vid[BOOT_LO]),
    .en_rise(en_rise), .active(active), .mode(mode), .boot_tgt(boot_tgt)
  );

  vid_code_filter #(.CODE_W(CODE_W)) u_filt (
    .clk(clk), .rst(rst), .en_rise(en_rise),
    .accept_en(active && (mode == MODE_PARALLEL)),
    .vid(vid), .new_code_vld(new_code_vld), .new_code(new_code)
  );

  vid_dac_stepper #(.CODE_W(CODE_W), .OFF_CODE(OFF_CODE)) u_step (
    .clk(clk), .rst(rst), .en(en), .en_rise(en_rise), .active(active),
    .boot_tgt(boot_tgt), .new_code_vld(new_code_vld), .new_code(new_code),
    .ss_tick(ss_tick), .slew_tick(slew_tick),
    .cur(dac_code), .done(ss_done), .step_evt(step_evt)
  );

  assign par_mode = (mode == MODE_PARALLEL);
  assign pgood    = ss_done && (par_mode || pwr_ok);
endmodule

// File: rtl/vid_target_seq_chk.sv
module vid_target_seq_chk #(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              ss_tick,
  input logic              slew_tick,
  input logic              pwr_ok,
  input logic [CODE_W-1:0] dac_code,
  input logic              par_mode,
  input logic              ss_done,
  input logic              pgood
);
  localparam logic [CODE_W-1:0] OFF_CODE = '1;

  function automatic logic near(input logic [CODE_W-1:0] a, input logic [CODE_W-1:0] b);
    int d;
    d = int'(a) - int'(b);
    return (d >= -1) && (d <= 1);
  endfunction

  // R5
  off_when_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (dac_code == OFF_CODE) && !ss_done);

  // R12
  one_lsb_chk: assert property (@(posedge clk) disable iff (rst)
    en && $past(en) |-> near(dac_code, $past(dac_code)));

  // R12
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
    en && $past(en) && !$past(ss_tick) && !$past(slew_tick) |-> $stable(dac_code));

  // R4
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ss_done && en |=> ss_done);

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    en && $past(en) && $past(en, 2) |-> $stable(par_mode));

  // R9
  par_pg_chk: assert property (@(posedge clk) disable iff (rst)
    par_mode && $changed(pwr_ok) |-> pgood == ss_done);
endmodule

bind vid_target_seq vid_target_seq_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .ss_tick(ss_tick), .slew_tick(slew_tick),
  .pwr_ok(pwr_ok), .dac_code(dac_code), .par_mode(par_mode),
  .ss_done(ss_done), .pgood(pgood)
);

// File: tb/vid_target_seq_tb.sv
module vid_target_seq_tb;
  logic       clk = 1'b0;
  logic       rst, en, ss_tick, slew_tick, pwr_ok;
  logic [5:0] vid;
  logic [5:0] dac_code;
  logic       par_mode, ss_done, pgood;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  vid_target_seq u_dut (
    .clk(clk), .rst(rst), .en(en), .vid(vid), .ss_tick(ss_tick),
    .slew_tick(slew_tick), .pwr_ok(pwr_ok), .dac_code(dac_code),
    .par_mode(par_mode), .ss_done(ss_done), .pgood(pgood)
  );

  // reference state
  logic [5:0] m_cur = 6'd63, m_tgt = 6'd63, m_acc = 0, m_prev = 0;
  bit m_active = 0, m_par = 0, m_done = 0, m_slew = 0, m_en_q = 0;

  function automatic logic [5:0] boot_code(input logic [5:0] v);
    case ({v[2], v[3]})
      2'b00: return 6'd18;  // 1.1 V
      2'b01: return 6'd22;  // 1.0 V
      2'b10: return 6'd26;  // 0.9 V
      default: return 6'd30; // 0.8 V
    endcase
  endfunction

  task automatic model_edge();
    logic [5:0] oc = m_cur, ot = m_tgt;
    bit os = m_slew, oa = m_active, tk;
    if (rst || !en) begin
      m_active = 0; m_par = 0; m_cur = 63; m_done = 0; m_slew = 0;
    end else if (!m_en_q) begin
      m_active = 1; m_par = vid[1]; m_tgt = boot_code(vid); m_acc = vid; m_slew = 0;
    end else if (oa) begin
      if (m_par && vid == m_prev && vid != m_acc) begin
        m_tgt = vid; m_acc = vid; m_slew = 1;
      end
      tk = os ? slew_tick : ss_tick;
      if (tk && oc != ot) m_cur = (oc < ot) ? oc + 6'd1 : oc - 6'd1;
      if (oc == ot) begin m_done = 1; m_slew = 1; end
    end
    m_en_q = rst ? 1'b0 : en;
    m_prev = rst ? 6'd0 : vid;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: model follows the edge, outputs compared 1 ns later
  task automatic cyc();
    @(posedge clk);
    model_edge();
    #1;
    chk("R3/R7 dac_code", dac_code, m_cur);
    chk("R4 ss_done", ss_done, m_done);
    chk("R2 par_mode", par_mode, m_par);
    chk("R9 pgood", pgood, m_done && (m_par || pwr_ok));
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [5:0] hold;
    void'($urandom(32'd1234));
    rst = 1; en = 0; vid = 0; ss_tick = 0; slew_tick = 0; pwr_ok = 0;
    run(3);
    rst = 0;
    run(2);
    chk("R5 reset code", dac_code, 63);
    chk("R5 reset done", ss_done, 0);

    // R1 R3 R4: parallel, boot index 01
    vid = 6'b001010; en = 1; ss_tick = 1;
    run(50);
    chk("R1 boot 01", dac_code, 22);
    chk("R4 done", ss_done, 1);
    chk("R2 parallel", par_mode, 1);
    pwr_ok = 0; run(1);
    chk("R9 pwr_ok ignored", pgood, 1);

    // R7 R8: redirect mid-ramp, then slew rate only
    en = 0; run(2);
    vid = 6'b001010; en = 1; run(6);
    vid = 6'd40; run(3);
    hold = dac_code;
    run(10);
    chk("R8 ss_tick ignored after accept", dac_code, hold);
    slew_tick = 1; run(40);
    chk("R7 redirected", dac_code, 40);
    chk("R6 accepted code reached", ss_done, 1);

    // R11: single-sample glitch
    vid = 6'd10; run(1);
    vid = 6'd40; run(20);
    chk("R11 glitch rejected", dac_code, 40);

    // R10 R9: serial, boot index 11
    en = 0; slew_tick = 0; run(2);
    chk("R5 disabled", dac_code, 63);
    vid = 6'b001100; en = 1; run(50);
    chk("R1 boot 11", dac_code, 30);
    chk("R2 serial", par_mode, 0);
    pwr_ok = 0; run(1);
    chk("R9 serial gated", pgood, 0);
    pwr_ok = 1; run(1);
    chk("R9 serial pass", pgood, 1);
    vid = 6'd5; slew_tick = 1; run(20);
    chk("R10 bus ignored", dac_code, 30);

    // random sessions
    for (int s = 0; s < 24; s++) begin
      en = 0; run(2 + $urandom % 3);
      vid = 6'($urandom);
      if (s % 3 != 0) vid[1] = 1'b1;
      en = 1;
      for (int c = 0; c < 250; c++) begin
        ss_tick   = ($urandom % 3) != 0;
        slew_tick = ($urandom % 4) == 0;
        pwr_ok    = ($urandom % 2) == 1;
        if ($urandom % 25 == 0) vid = 6'($urandom);
        else if ($urandom % 40 == 0) begin
          hold = vid; vid = 6'($urandom); cyc(); vid = hold;
        end
        if (s % 5 == 4 && c == 120) begin
          en = 0; run(2); en = 1;
        end
        cyc();
      end
    end
    en = 0; run(3);
    chk("R5 final off", dac_code, 63);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule